// File: doc/BRIEF.md
# Frame-Level Rescheduled Motion-Estimation Task Sequencer

This block decides the order in which a motion-estimation core works through the tasks of a multi-reference-frame search. It does not run the conventional order, where each current macroblock visits all of its reference frames in turn. Instead, each reconstructed frame is treated as the search source for several later frames. While the search window of one macroblock position in that reconstructed frame is resident, the sequencer issues the tasks for the co-located macroblocks of the following current frames back to back. The window is therefore fetched once and used up to four times.

Each task carries four values: the time of the current frame, the time of the reference frame, the macroblock index, and the reference distance (1 to the configured maximum). The reference distance is the difference between the current frame time and the reference frame time. With every task the block raises two requests. One loads the current macroblock, on every task, because only one current-macroblock buffer exists. The other loads a search window, only on the first task of each window group. A start pulse begins the schedule. Each done handshake from the core moves it to the next task. A one-cycle completion pulse follows the last task.

Frame 0 is the already-coded intra frame, and P-frames 1 to `NUM_FRAMES` are scheduled. A task whose current frame would lie past the last frame to code is never issued. As a result, the early P-frames see fewer references, and so do the windows taken from late reference frames.

Top module: `fls_sched`

## Requirements
- R1: During and directly after reset, `task_valid_o` and `sched_done_o` are low.
- R2: A `start_i` pulse while idle presents, on the next cycle, the first task: current time 1, reference time 0, macroblock 0, reference distance 1.
- R3: Tasks advance through reference distance first (ascending from 1), then macroblock index (ascending from 0), then reference time (ascending from 0).
- R4: Every issued task has current time equal to reference time plus reference distance, with reference distance between 1 and `MAX_REF`.
- R5: No task has a current time above `NUM_FRAMES`. For reference time r the window group therefore holds min(`MAX_REF`, `NUM_FRAMES` − r) tasks, and the schedule holds the sum of these over all r, times `NUM_MB`.
- R6: `sw_load_o` is high with a valid task exactly when its reference distance is 1, that is, on the first task of each window group.
- R7: `cb_load_o` is high with every valid task.
- R8: The presented task and its indices stay unchanged until `me_done_i` is seen high. The next task appears on the cycle after that handshake.
- R9: The handshake of the last task is followed by `sched_done_o` high for exactly one cycle, with `task_valid_o` low, and the block is then idle.
- R10: `start_i` while a schedule is running and `me_done_i` while idle have no effect: the presented task is unchanged, or the block stays idle and the next start begins again at the first task.
- R11: With `MAX_REF` = 1 every group holds one task, so every task has reference distance 1, raises `sw_load_o`, and follows the conventional macroblock-then-frame order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a schedule (sampled while idle) |
| me_done_i | input | 1 | Core has finished the presented task |
| task_valid_o | output | 1 | A task is presented |
| cur_time_o | output | TW | Current frame time of the task |
| ref_time_o | output | TW | Reference frame time of the task |
| mb_idx_o | output | MW | Macroblock index within the frame |
| ref_idx_o | output | KW | Reference distance (1..MAX_REF) |
| sw_load_o | output | 1 | Request to load the search window |
| cb_load_o | output | 1 | Request to load the current macroblock |
| sched_done_o | output | 1 | One-cycle pulse after the last task |

## Verification
The main instance is built with three macroblocks, five P-frames and four references. These values make the window groups shrink from four tasks to one toward the end of the sequence, so both the full and the truncated group lengths appear, along with macroblock and frame wrap-around. A second instance with two macroblocks, three frames and a single reference selects the conventional variant, in which every task opens its own window. Ignored inputs are exercised mid-schedule and while idle, and the effect is judged from the presented task and from a restart.

// File: rtl/fls_pkg.sv
package fls_pkg;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } fls_state_e;

   function automatic int fls_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/fls_ctr.sv
module fls_ctr #(
   parameter int W    = 4,
   parameter int INIT = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= W'(INIT);
      else if (clr) q <= W'(INIT);
      else if (inc) q <= q + W'(1);
   end
endmodule

// File: rtl/fls_step.sv
module fls_step #(
   parameter int NUM_MB     = 4,
   parameter int NUM_FRAMES = 8,
   parameter int MAX_REF    = 4,
   parameter int TW         = 4,
   parameter int MW         = 2,
   parameter int KW         = 3
) (
   input  logic [TW-1:0] ref_t,
   input  logic [MW-1:0] mb,
   input  logic [KW-1:0] k,
   output logic [TW-1:0] cur_t,
   output logic          k_end,
   output logic          m_end,
   output logic          last
);
   localparam int SW = TW + 1;

   logic [SW-1:0] sum_w;
   logic          r_end;

   assign sum_w = SW'(ref_t) + SW'(k);
   assign cur_t = sum_w[TW-1:0];
   assign m_end = (mb == MW'(NUM_MB - 1));
   assign r_end = (ref_t == TW'(NUM_FRAMES - 1));

   generate
      if (MAX_REF == 1) begin : g_single
         assign k_end = 1'b1;
      end else begin : g_multi
         assign k_end = (k == KW'(MAX_REF)) || (sum_w >= SW'(NUM_FRAMES));
      end
   endgenerate

   assign last = k_end & m_end & r_end;
endmodule

// File: rtl/fls_sched.sv
module fls_sched #(
   parameter  int NUM_MB     = 396,
   parameter  int NUM_FRAMES = 30,
   parameter  int MAX_REF    = 4,
   localparam int TW         = fls_pkg::fls_width(NUM_FRAMES + 1),
   localparam int MW         = fls_pkg::fls_width(NUM_MB),
   localparam int KW         = fls_pkg::fls_width(MAX_REF + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic          me_done_i,
   output logic          task_valid_o,
   output logic [TW-1:0] cur_time_o,
   output logic [TW-1:0] ref_time_o,
   output logic [MW-1:0] mb_idx_o,
   output logic [KW-1:0] ref_idx_o,
   output logic          sw_load_o,
   output logic          cb_load_o,
   output logic          sched_done_o
);
   import fls_pkg::*;

   initial begin
      assert (MAX_REF >= 1 && MAX_REF <= 4) else $error("MAX_REF must be 1..4");
      assert (NUM_FRAMES >= 1) else $error("NUM_FRAMES must be at least 1");
      assert (NUM_MB >= 1) else $error("NUM_MB must be at least 1");
   end

   fls_state_e    state_q;
   logic          done_q;
   logic          go, adv;
   logic          k_end, m_end, last;
   logic [TW-1:0] ref_t, cur_t;
   logic [MW-1:0] mb;
   logic [KW-1:0] k;

   assign go  = (state_q == ST_IDLE) && start_i;
   assign adv = (state_q == ST_RUN) && me_done_i;

   fls_ctr #(.W(KW), .INIT(1)) u_k_ctr (
      .clk(clk), .rst_n(rst_n),
      .clr(go | (adv & k_end)), .inc(adv), .q(k)
   );

   fls_ctr #(.W(MW), .INIT(0)) u_mb_ctr (
      .clk(clk), .rst_n(rst_n),
      .clr(go | (adv & k_end & m_end)), .inc(adv & k_end), .q(mb)
   );

   fls_ctr #(.W(TW), .INIT(0)) u_ref_ctr (
      .clk(clk), .rst_n(rst_n),
      .clr(go), .inc(adv & k_end & m_end), .q(ref_t)
   );

   fls_step #(
      .NUM_MB(NUM_MB), .NUM_FRAMES(NUM_FRAMES), .MAX_REF(MAX_REF),
      .TW(TW), .MW(MW), .KW(KW)
   ) u_step (
      .ref_t(ref_t), .mb(mb), .k(k),
      .cur_t(cur_t), .k_end(k_end), .m_end(m_end), .last(last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         done_q  <= 1'b0;
      end else begin
         done_q <= adv & last;
         if (go)                state_q <= ST_RUN;
         else if (adv && last)  state_q <= ST_IDLE;
      end
   end

   assign task_valid_o = (state_q == ST_RUN);
   assign cur_time_o   = cur_t;
   assign ref_time_o   = ref_t;
   assign mb_idx_o     = mb;
   assign ref_idx_o    = k;
   assign sw_load_o    = task_valid_o && (k == KW'(1));
   assign cb_load_o    = task_valid_o;
   assign sched_done_o = done_q;
endmodule

// File: rtl/fls_sched_chk.sv
module fls_sched_chk #(
   parameter int NUM_FRAMES = 30,
   parameter int MAX_REF    = 4,
   parameter int TW         = 5,
   parameter int MW         = 9,
   parameter int KW         = 3
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start_i,
   input logic          me_done_i,
   input logic          task_valid_o,
   input logic [TW-1:0] cur_time_o,
   input logic [TW-1:0] ref_time_o,
   input logic [MW-1:0] mb_idx_o,
   input logic [KW-1:0] ref_idx_o,
   input logic          sw_load_o,
   input logic          sched_done_o
);
   p_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (task_valid_o && !me_done_i) |=> (task_valid_o && $stable(cur_time_o)
         && $stable(ref_time_o) && $stable(mb_idx_o) && $stable(ref_idx_o)));

   p_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      task_valid_o |-> (cur_time_o <= TW'(NUM_FRAMES) && ref_idx_o >= KW'(1)
         && ref_idx_o <= KW'(MAX_REF)));

   p_open_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(task_valid_o) |-> sw_load_o);

   p_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (task_valid_o && me_done_i) |=> (!task_valid_o || ref_idx_o == KW'(1)
         || ref_idx_o == $past(ref_idx_o) + KW'(1)));

   p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      sched_done_o |=> !sched_done_o);

   p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      sched_done_o |-> !task_valid_o);

   p_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!task_valid_o && !start_i) |=> !task_valid_o);
endmodule

bind fls_sched fls_sched_chk #(
   .NUM_FRAMES(NUM_FRAMES), .MAX_REF(MAX_REF), .TW(TW), .MW(MW), .KW(KW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .start_i(start_i), .me_done_i(me_done_i),
   .task_valid_o(task_valid_o), .cur_time_o(cur_time_o),
   .ref_time_o(ref_time_o), .mb_idx_o(mb_idx_o), .ref_idx_o(ref_idx_o),
   .sw_load_o(sw_load_o), .sched_done_o(sched_done_o)
);

// File: tb/fls_sched_bench.sv
`timescale 1ns/1ps
module fls_sched_bench;
   localparam int A_MB = 3, A_NF = 5, A_MR = 4;
   localparam int B_MB = 2, B_NF = 3, B_MR = 1;
   // expected group length per reference time: min(MAX_REF, NUM_FRAMES - r)
   localparam int GRP_LEN [A_NF] = '{4, 4, 3, 2, 1};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_a = 1'b0, done_a = 1'b0;
   logic start_b = 1'b0, done_b = 1'b0;
   int   checks = 0;
   int   errors = 0;
   int   cycles = 0;

   always #2.5 clk = ~clk;

   logic       va, swa, cba, fa;
   logic [2:0] cura, refa, ka;
   logic [1:0] mba;
   logic       vb, swb, cbb, fb;
   logic [1:0] curb, refb;
   logic       mbb;
   logic       kb;

   fls_sched #(.NUM_MB(A_MB), .NUM_FRAMES(A_NF), .MAX_REF(A_MR)) u_fls_sched (
      .clk(clk), .rst_n(rst_n), .start_i(start_a), .me_done_i(done_a),
      .task_valid_o(va), .cur_time_o(cura), .ref_time_o(refa),
      .mb_idx_o(mba), .ref_idx_o(ka), .sw_load_o(swa), .cb_load_o(cba),
      .sched_done_o(fa)
   );

   fls_sched #(.NUM_MB(B_MB), .NUM_FRAMES(B_NF), .MAX_REF(B_MR)) u_fls_sched_single (
      .clk(clk), .rst_n(rst_n), .start_i(start_b), .me_done_i(done_b),
      .task_valid_o(vb), .cur_time_o(curb), .ref_time_o(refb),
      .mb_idx_o(mbb), .ref_idx_o(kb), .sw_load_o(swb), .cb_load_o(cbb),
      .sched_done_o(fb)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic chk_task_a(input string req, input int c, input int r,
                             input int m, input int k);
      chk({req, " valid"}, int'(va), 1);
      chk({req, " R4 cur"}, int'(cura), c);
      chk({req, " reftime"}, int'(refa), r);
      chk({req, " mb"}, int'(mba), m);
      chk({req, " R4 dist"}, int'(ka), k);
      chk({req, " R6 sw_load"}, int'(swa), (k == 1) ? 1 : 0);
      chk({req, " R7 cb_load"}, int'(cba), 1);
   endtask

   task automatic handshake_a();
      done_a = 1'b1;
      @(negedge clk);
      done_a = 1'b0;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         errors++;
         $display("FAIL watchdog actual %0d expected below 20000", cycles);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int n_tasks;
      repeat (3) @(negedge clk);
      chk("R1 valid in reset", int'(va), 0);
      chk("R1 done in reset", int'(fa), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 valid after reset", int'(va), 0);
      chk("R1 done after reset", int'(fa), 0);

      start_a = 1'b1;
      @(negedge clk);
      start_a = 1'b0;
      chk_task_a("R2 first", 1, 0, 0, 1);

      // R10: start while running is ignored
      start_a = 1'b1;
      @(negedge clk);
      start_a = 1'b0;
      chk_task_a("R10 start ignored", 1, 0, 0, 1);

      // R8: no handshake, task held
      repeat (3) @(negedge clk);
      chk_task_a("R8 held", 1, 0, 0, 1);

      // R3/R5 walk of the whole schedule from the group-length table
      n_tasks = 0;
      for (int r = 0; r < A_NF; r++) begin
         for (int m = 0; m < A_MB; m++) begin
            for (int k = 1; k <= GRP_LEN[r]; k++) begin
               chk_task_a("R3 order", r + k, r, m, k);
               chk("R9 no early done", int'(fa), 0);
               n_tasks++;
               handshake_a();
            end
         end
      end
      chk("R5 task count", n_tasks, 42);
      chk("R9 done pulse", int'(fa), 1);
      chk("R9 idle at done", int'(va), 0);
      @(negedge clk);
      chk("R9 done one cycle", int'(fa), 0);
      chk("R9 stays idle", int'(va), 0);

      // R10: handshake while idle is ignored
      handshake_a();
      chk("R10 idle handshake valid", int'(va), 0);
      chk("R10 idle handshake done", int'(fa), 0);
      start_a = 1'b1;
      @(negedge clk);
      start_a = 1'b0;
      chk_task_a("R10 restart first", 1, 0, 0, 1);
      handshake_a();
      chk_task_a("R3 second", 2, 0, 0, 2);

      // R11: single-reference variant, conventional order
      start_b = 1'b1;
      @(negedge clk);
      start_b = 1'b0;
      for (int r = 0; r < B_NF; r++) begin
         for (int m = 0; m < B_MB; m++) begin
            chk("R11 valid", int'(vb), 1);
            chk("R11 cur", int'(curb), r + 1);
            chk("R11 reftime", int'(refb), r);
            chk("R11 mb", int'(mbb), m);
            chk("R11 dist", int'(kb), 1);
            chk("R11 sw_load", int'(swb), 1);
            chk("R11 cb_load", int'(cbb), 1);
            done_b = 1'b1;
            @(negedge clk);
            done_b = 1'b0;
         end
      end
      chk("R11 done pulse", int'(fb), 1);
      chk("R11 idle", int'(vb), 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule